// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block sits beside a processor core and decides when the core should leave its instruction stream to serve an external event. Several request lines come in. Each has its own enable bit, and a single global enable gates them all. At an instruction boundary the block picks the lowest-numbered enabled request and redirects the core to a handler address computed from that source's number. It pulses an acknowledge back to that source.

When the redirect happens, the global enable is turned off and its previous value is kept in a saved-enable bit. The core's return address is latched for the core to push. A return strobe then sends the latched address back as the next PC and restores the global enable from the saved bit, which re-arms the controller for the next request.

All outputs are registered. A decision made at clock edge k appears on the outputs right after edge k and lasts one cycle where it is a pulse.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the following are all cleared after that edge: the global enable, the saved enable, the mask, the cause register, the return PC, the PC output, take_irq, pc_load and every acknowledge bit.
- R2: A high `mask_wr` at an edge loads `mask_wdata` into the per-source mask, which reads back on `mask_q`. A request whose mask bit is 0 never causes an interrupt and is never acknowledged.
- R3: An interrupt is taken at an edge only if all four hold: the global enable is 1, `insn_done` is 1, `ret_strobe` is 0, and at least one enabled request is high. `take_irq` is high for the one cycle after that edge.
- R4: When several enabled requests are pending, the lowest-numbered one wins. `irq_ack` carries a single bit at that source's position for exactly the cycle that `take_irq` is high, and is zero otherwise.
- R5: In the cycle after a take, `pc_load` is 1 and `pc_next` equals VEC_BASE + source_number × VEC_STRIDE.
- R6: On a take, `cause_q` is loaded with every enabled request that is high at that edge, so it may have more than one bit set. It holds until the next take.
- R7: A take clears the global enable, copies the old global enable into `saved_ie_q` and latches `ret_pc_in` into `ret_pc_q`. While the global enable stays 0, no further take happens.
- R8: A high `ret_strobe` at an edge has two effects in the next cycle: `pc_load` is 1 with `pc_next` equal to `ret_pc_q`, and the global enable takes the value of `saved_ie_q`. A return in the same cycle as a take condition wins, and no take happens.
- R9: A high `ie_wr` at an edge sets the global enable to `ie_wdata`, unless a return or a take happens at that same edge. In that case the return or the take decides the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | N_SRC | Level-sensitive request lines, bit i is source i |
| mask_wr | input | 1 | Load the per-source mask |
| mask_wdata | input | N_SRC | New mask value |
| ie_wr | input | 1 | Write the global enable |
| ie_wdata | input | 1 | New global enable value |
| insn_done | input | 1 | Current instruction has just finished |
| ret_pc_in | input | AW | Address to resume at after the handler |
| ret_strobe | input | 1 | Return-from-interrupt |
| take_irq | output | 1 | Interrupt taken (one-cycle pulse) |
| irq_ack | output | N_SRC | One-hot acknowledge to the served source |
| pc_load | output | 1 | Core must load pc_next |
| pc_next | output | AW | Handler vector or return address |
| cause_q | output | N_SRC | Enabled requests seen at the last take |
| gie_q | output | 1 | Global interrupt enable |
| saved_ie_q | output | 1 | Enable value saved by the last take |
| ret_pc_q | output | AW | Latched return address |
| mask_q | output | N_SRC | Per-source mask |

## Verification
The bench builds the block with six sources, a base of 0x8000_0040 and a stride of 12. A stride that is not a power of two makes every vector depend on a real multiply-add, so a slip in the index or the stride changes the expected address. Six sources is not a power of two, so some index values are unused and the top source sits at the edge of the encoder. Seeded random requests, masks, boundaries and returns exercise overlapping pending sources, returns colliding with takes, and enable writes colliding with both.

// File: rtl/ivc_pkg.sv
// Shared definitions for the vectored interrupt controller.
// Assumes nothing beyond a standard SystemVerilog package.
package ivc_pkg;

    // Which single event updates the enable/status state at an edge.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_TAKE = 2'd1,
        EV_RET  = 2'd2,
        EV_IEWR = 2'd3
    } ev_t;

endpackage

// File: rtl/ivc_prio.sv
// Fixed-priority picker: lowest index among the asserted requests wins.
// Assumes N >= 2; outputs are purely combinational.
module ivc_prio #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Ripple chain: a request is granted only if no lower index is asserted.
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1] = seen[i] | req[i];
        assign grant[i]  = req[i] & ~seen[i];
    end

    assign any = seen[N];

    // Encode the granted position into a source number.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Grant is never more than one bit and exists exactly when a request does.
    always_comb begin
        assert_grant_onehot_R4: assert ($onehot0(grant) && ((|grant) == any));
    end

endmodule

// File: rtl/ivc_vecgen.sv
// Handler address generator: base plus source number times stride.
// Assumes the result fits in AW bits; overflow wraps.
module ivc_vecgen #(
    parameter int             N          = 8,
    parameter int             IDX_W      = $clog2(N),
    parameter int             AW         = 32,
    parameter logic [AW-1:0]  VEC_BASE   = 32'h8000_0000,
    parameter int unsigned    VEC_STRIDE = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr
);

    localparam logic [AW-1:0] STRIDE_W = AW'(VEC_STRIDE);

    // Multiply-add; a power-of-two stride reduces to a shift.
    assign addr = VEC_BASE + AW'(idx) * STRIDE_W;

endmodule

// File: rtl/ivc_status.sv
// Status state: global enable, saved enable and return PC.
// Assumes the caller resolves event priority into a single ev_t per cycle.
module ivc_status #(
    parameter int AW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ivc_pkg::ev_t   ev,
    input  logic           ie_wdata,
    input  logic [AW-1:0]  ret_pc_in,
    output logic           gie,
    output logic           saved_ie,
    output logic [AW-1:0]  ret_pc
);

    import ivc_pkg::*;

    // Apply the cycle's event to the enable bits and return address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie      <= 1'b0;
            saved_ie <= 1'b0;
            ret_pc   <= '0;
        end else begin
            unique case (ev)
                EV_TAKE: begin
                    saved_ie <= gie;
                    gie      <= 1'b0;
                    ret_pc   <= ret_pc_in;
                end
                EV_RET:  gie <= saved_ie;
                EV_IEWR: gie <= ie_wdata;
                default: ;
            endcase
        end
    end

    // A take leaves interrupts off and remembers the enable it found.
    assert_take_saves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_TAKE) |=> (!gie && saved_ie == $past(gie) && ret_pc == $past(ret_pc_in)));

    // A return restores the enable from the saved copy.
    assert_ret_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RET) |=> (gie == $past(saved_ie)));

endmodule

// File: rtl/irq_vector_ctrl.sv
// Vectored interrupt controller top: masks requests, picks the winner at an
// instruction boundary, emits a one-cycle take/ack with the handler vector,
// and sends the core back on a return strobe.
// Assumes requests stay high until acknowledged; all outputs are registered.
module irq_vector_ctrl #(
    parameter int             N_SRC      = 8,
    parameter int             AW         = 32,
    parameter logic [AW-1:0]  VEC_BASE   = 32'h8000_0000,
    parameter int unsigned    VEC_STRIDE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req,
    input  logic             mask_wr,
    input  logic [N_SRC-1:0] mask_wdata,
    input  logic             ie_wr,
    input  logic             ie_wdata,
    input  logic             insn_done,
    input  logic [AW-1:0]    ret_pc_in,
    input  logic             ret_strobe,
    output logic             take_irq,
    output logic [N_SRC-1:0] irq_ack,
    output logic             pc_load,
    output logic [AW-1:0]    pc_next,
    output logic [N_SRC-1:0] cause_q,
    output logic             gie_q,
    output logic             saved_ie_q,
    output logic [AW-1:0]    ret_pc_q,
    output logic [N_SRC-1:0] mask_q
);

    import ivc_pkg::*;

    localparam int IDX_W = $clog2(N_SRC);

    logic [N_SRC-1:0] pending;
    logic [N_SRC-1:0] grant;
    logic [IDX_W-1:0] win_idx;
    logic             win_any;
    logic [AW-1:0]    vec_addr;
    ev_t              ev;

    assign pending = irq_req & mask_q;

    ivc_prio #(.N(N_SRC), .IDX_W(IDX_W)) u_prio (
        .req   (pending),
        .grant (grant),
        .idx   (win_idx),
        .any   (win_any)
    );

    ivc_vecgen #(
        .N(N_SRC), .IDX_W(IDX_W), .AW(AW),
        .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_vec (
        .idx  (win_idx),
        .addr (vec_addr)
    );

    // Resolve this cycle's event: return beats take, take beats enable write.
    always_comb begin
        if (ret_strobe)                          ev = EV_RET;
        else if (gie_q && insn_done && win_any)  ev = EV_TAKE;
        else if (ie_wr)                          ev = EV_IEWR;
        else                                     ev = EV_NONE;
    end

    ivc_status #(.AW(AW)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .ie_wdata  (ie_wdata),
        .ret_pc_in (ret_pc_in),
        .gie       (gie_q),
        .saved_ie  (saved_ie_q),
        .ret_pc    (ret_pc_q)
    );

    // Per-source mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    // Registered take/ack pulses, PC redirect and cause capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_irq <= 1'b0;
            irq_ack  <= '0;
            pc_load  <= 1'b0;
            pc_next  <= '0;
            cause_q  <= '0;
        end else begin
            take_irq <= (ev == EV_TAKE);
            irq_ack  <= (ev == EV_TAKE) ? grant : '0;
            pc_load  <= (ev == EV_TAKE) || (ev == EV_RET);
            if (ev == EV_TAKE) begin
                pc_next <= vec_addr;
                cause_q <= pending;
            end else if (ev == EV_RET) begin
                pc_next <= ret_pc_q;
            end
        end
    end

    // Acknowledge is at most one source and only alongside a take.
    assert_ack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack) && ((|irq_ack) == take_irq));

    // A take only follows an instruction boundary with interrupts enabled.
    assert_take_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> ($past(insn_done) && $past(gie_q) && !$past(ret_strobe)));

    // The acknowledged source is recorded in the cause register.
    assert_ack_in_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> ((irq_ack & cause_q) == irq_ack));

    // A masked source is never acknowledged.
    assert_masked_no_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> ((irq_ack & ~$past(mask_q)) == '0));

    // A redirect that is not a take returns to the latched address.
    assert_ret_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !take_irq) |-> (pc_next == ret_pc_q));

    // A take always redirects the core.
    assert_take_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> pc_load);

endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/100ps
module sim_irq_vector_ctrl;

    localparam int          N    = 6;
    localparam int          AW   = 32;
    localparam logic [31:0] BASE = 32'h8000_0040;
    localparam int unsigned STR  = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  irq_req, mask_wdata;
    logic          mask_wr, ie_wr, ie_wdata, insn_done, ret_strobe;
    logic [AW-1:0] ret_pc_in;
    logic          take_irq, pc_load, gie_q, saved_ie_q;
    logic [N-1:0]  irq_ack, cause_q, mask_q;
    logic [AW-1:0] pc_next, ret_pc_q;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state
    logic          m_gie, m_sav, m_take, m_load;
    logic [N-1:0]  m_mask, m_cause, m_ack;
    logic [AW-1:0] m_epc, m_pc;

    always #2.5 clk = ~clk;

    irq_vector_ctrl #(.N_SRC(N), .AW(AW), .VEC_BASE(BASE), .VEC_STRIDE(STR)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
        .insn_done(insn_done), .ret_pc_in(ret_pc_in), .ret_strobe(ret_strobe),
        .take_irq(take_irq), .irq_ack(irq_ack), .pc_load(pc_load),
        .pc_next(pc_next), .cause_q(cause_q), .gie_q(gie_q),
        .saved_ie_q(saved_ie_q), .ret_pc_q(ret_pc_q), .mask_q(mask_q)
    );

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [AW-1:0] vector_of(input int src);
        return BASE + AW'(src) * AW'(STR);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        mask_wr = 0; mask_wdata = '0; ie_wr = 0; ie_wdata = 0;
        insn_done = 0; ret_strobe = 0;
    endtask

    // One clock: predict from current inputs, advance, compare all outputs.
    task automatic tick();
        logic [N-1:0] pend;
        logic tk, rt;
        pend = irq_req & m_mask;
        rt   = ret_strobe;
        tk   = !rt && m_gie && insn_done && (pend != '0);
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_gie = 0; m_sav = 0; m_take = 0; m_load = 0;
            m_mask = '0; m_cause = '0; m_ack = '0; m_epc = '0; m_pc = '0;
        end else begin
            m_take = tk;
            m_ack  = tk ? N'(1) << lowest(pend) : '0;
            m_load = tk || rt;
            if (tk) begin
                m_pc = vector_of(lowest(pend)); m_cause = pend;
                m_sav = m_gie; m_gie = 0; m_epc = ret_pc_in;
            end else if (rt) begin
                m_pc = m_epc; m_gie = m_sav;
            end else if (ie_wr) begin
                m_gie = ie_wdata;
            end
            if (mask_wr) m_mask = mask_wdata;
        end
        chk("R3 take_irq", 64'(take_irq), 64'(m_take));
        chk("R4 irq_ack", 64'(irq_ack), 64'(m_ack));
        chk("R5/R8 pc_load", 64'(pc_load), 64'(m_load));
        chk("R5/R8 pc_next", 64'(pc_next), 64'(m_pc));
        chk("R6 cause_q", 64'(cause_q), 64'(m_cause));
        chk("R7/R8/R9 gie_q", 64'(gie_q), 64'(m_gie));
        chk("R7 saved_ie_q", 64'(saved_ie_q), 64'(m_sav));
        chk("R7 ret_pc_q", 64'(ret_pc_q), 64'(m_epc));
        chk("R2 mask_q", 64'(mask_q), 64'(m_mask));
    endtask

    initial begin
        #500us;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; irq_req = '1; ret_pc_in = 32'h1234; idle_inputs();
        m_gie = 0; m_sav = 0; m_take = 0; m_load = 0;
        m_mask = '0; m_cause = '0; m_ack = '0; m_epc = '0; m_pc = '0;
        repeat (3) tick();
        // R1: reset state
        chk("R1 reset gie", 64'(gie_q), 64'd0);
        chk("R1 reset take", 64'(take_irq), 64'd0);
        chk("R1 reset mask", 64'(mask_q), 64'd0);
        rst_n = 1; irq_req = '0;

        // R2: masked requests do nothing even with enable and boundary
        ie_wr = 1; ie_wdata = 1; mask_wr = 1; mask_wdata = 6'b000010; tick();
        idle_inputs(); irq_req = 6'b111101; insn_done = 1; tick();
        chk("R2 masked no take", 64'(take_irq), 64'd0);

        // R3: enabled pending but no boundary -> no take
        mask_wr = 1; mask_wdata = '1; insn_done = 0; irq_req = 6'b101000; tick();
        mask_wr = 0; tick();
        chk("R3 no boundary no take", 64'(take_irq), 64'd0);

        // R4/R5/R6/R7: boundary -> source 3 wins, cause has 3 and 5
        insn_done = 1; ret_pc_in = 32'hABCD_0010; tick();
        chk("R4 ack source3", 64'(irq_ack), 64'b001000);
        chk("R5 vector src3", 64'(pc_next), 64'(vector_of(3)));
        chk("R6 cause two bits", 64'(cause_q), 64'b101000);
        chk("R7 gie cleared", 64'(gie_q), 64'd0);
        tick();
        chk("R4 ack one cycle", 64'(irq_ack), 64'd0);
        chk("R7 no retake while disabled", 64'(take_irq), 64'd0);

        // R8: return restores enable and PC; return beats take
        irq_req = 6'b100000; ret_strobe = 1; tick();
        chk("R8 ret pc", 64'(pc_next), 64'h0000_0000_ABCD_0010);
        chk("R8 gie restored", 64'(gie_q), 64'd1);
        ret_strobe = 1; tick();
        chk("R8 ret beats take", 64'(take_irq), 64'd0);
        ret_strobe = 0; ie_wr = 1; ie_wdata = 0; tick();
        chk("R5 top source vector", 64'(pc_next), 64'(vector_of(5)));
        chk("R9 take beats ie write", 64'(gie_q), 64'd0);
        idle_inputs(); ie_wr = 1; ie_wdata = 1; tick();
        chk("R9 ie write", 64'(gie_q), 64'd1);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            irq_req    = N'($urandom);
            insn_done  = ($urandom % 3) != 0;
            ret_strobe = ($urandom % 7) == 0;
            mask_wr    = ($urandom % 9) == 0;
            mask_wdata = N'($urandom);
            ie_wr      = ($urandom % 5) == 0;
            ie_wdata   = ($urandom % 4) != 0;
            ret_pc_in  = $urandom;
            tick();
        end
        idle_inputs();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule